// File: doc/BRIEF.md
# SPI Master with Read-Triggered Word Exchange

This block is an SPI bus master that a processor controls through six 16-bit registers on a simple register bus. It does not start a word when the transmit register is written. It starts a word when software reads the receive data register. That read returns the word received last, clears the completion flag and shifts out the current transmit register contents. The software loop is therefore short: read the result, and the next exchange is already running. A second read address, the shadow, returns the same received word with no side effect.

Word size, bit order, clock polarity and clock phase are set by control bits. The SCK rate comes from a 16-bit divider. The chip-select line is a plain control bit that software drives. When the enable bit is cleared, the output-enable pin drops so that SCK, MOSI and chip-select float. A level interrupt marks the end of each word.

Register addresses: 0 control, 1 divider, 2 transmit, 3 receive (triggering), 4 shadow, 5 status.

Control bits:

| Bit | Meaning |
|-----|---------|
| 0 | enable |
| 1 | master |
| 2 | CPOL |
| 3 | CPHA |
| 4 | LSB-first |
| 5 | 16-bit size |
| 6 | chip-select level |

Status bits: bit 0 is the completion flag and bit 1 is busy.

Top module: `spi_rt_master`

## Requirements
- R1: After reset the registers hold these values: control reads 0x0043 (enabled, master, chip-select high), divider reads 4, status reads 0, `irq_o` is 0, `cs_no` is 1 and `io_oe_o` is 1.
- R2: A bus read of address 3 while enabled and idle returns the last received word, sets busy (status bit 1) from the next cycle and starts an exchange of the transmit register.
- R3: A read of address 4 returns the last received word, starts no exchange and leaves the completion flag set.
- R4: The SCK half-period is max(divider, 2) system clocks. The flag rises exactly 2·N·max(divider,2) cycles after the triggering read edge, where N is the word size.
- R5: Control bit 5 set selects 16-bit words; clear selects 8-bit words. In 8-bit mode only the transmit low byte is shifted and the received word has a zero upper byte.
- R6: Control bit 4 set shifts least significant bit first on both MOSI and MISO; clear shifts most significant bit first.
- R7: `sck_o` idles at control bit 2 (CPOL). With control bit 3 (CPHA) clear, data is valid before the first edge and is sampled on leading edges. With CPHA set, data changes on leading edges and is sampled on trailing edges.
- R8: With control bit 0 clear, `io_oe_o` is 0, and a read of address 3 clears the flag without starting an exchange.
- R9: `irq_o` equals status bit 0. It is set at the final SCK edge of a word and cleared by a read of address 3.
- R10: Busy is high from the trigger until the final SCK edge. A read of address 3 while busy neither restarts nor lengthens the exchange.
- R11: `cs_no` follows control bit 6 and does not change during exchanges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| bus_addr_i | input | 3 | register address |
| bus_wr_i | input | 1 | write strobe, one cycle |
| bus_rd_i | input | 1 | read strobe, one cycle; side effects on the clock edge |
| bus_wdata_i | input | 16 | write data |
| bus_rdata_o | output | 16 | read data for bus_addr_i, combinational |
| irq_o | output | 1 | word-complete interrupt, level |
| sck_o | output | 1 | serial clock |
| mosi_o | output | 1 | serial data out |
| miso_i | input | 1 | serial data in |
| cs_no | output | 1 | chip select, active low |
| io_oe_o | output | 1 | output enable for SCK, MOSI and chip select |

## Verification
The bench runs all sixteen combinations of polarity, phase, bit order and word size against a modelled slave. The slave returns a word different from the one transmitted, so a swapped direction, a reversed order or a wrong size shows up as a data mismatch on one side or the other. A divider sweep over 0, 1, 3, 5 and 7 separates the clamp-to-2 behaviour from a plain divide, because the two give different cycle counts to the flag. Separate sequences try a trigger read while busy, a trigger read while disabled and shadow reads. These show which reads start an exchange and which only clear or keep the flag.

// File: rtl/spi_rt_pkg.sv
package spi_rt_pkg;
  localparam int DW = 16;
  localparam int AW = 3;

  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_BAUD = 3'd1;
  localparam logic [AW-1:0] A_TXD  = 3'd2;
  localparam logic [AW-1:0] A_RXD  = 3'd3;
  localparam logic [AW-1:0] A_SHD  = 3'd4;
  localparam logic [AW-1:0] A_STAT = 3'd5;

  localparam int CB_EN   = 0;
  localparam int CB_MSTR = 1;
  localparam int CB_CPOL = 2;
  localparam int CB_CPHA = 3;
  localparam int CB_LSBF = 4;
  localparam int CB_SIZE = 5;
  localparam int CB_CS   = 6;
  localparam int CW      = 7;

  localparam logic [CW-1:0] CTRL_RST = 7'h43;
  localparam logic [DW-1:0] BAUD_RST = 16'd4;
endpackage

// File: rtl/spi_rt_clkgen.sv
module spi_rt_clkgen #(
  parameter  int DW = 16,
  localparam int EW = $clog2(2*DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] baud_i,
  input  logic          cpol_i,
  input  logic          size16_i,
  output logic          sck_o,
  output logic          busy_o,
  output logic          lead_o,
  output logic          trail_o,
  output logic          first_o,
  output logic          last_o,
  output logic          fin_o
);
  logic [DW-1:0] half, hcnt;
  logic [EW-1:0] ecnt;
  logic          ph, busy_q, tick;

  assign half    = (baud_i < DW'(2)) ? DW'(2) : baud_i;
  assign tick    = busy_q && (hcnt >= half - DW'(1));
  assign last_o  = ecnt == (size16_i ? EW'(2*DW-1) : EW'(15));
  assign first_o = ecnt == '0;
  assign lead_o  = tick && !ph;
  assign trail_o = tick && ph;
  assign fin_o   = tick && last_o;
  assign sck_o   = cpol_i ^ ph;
  assign busy_o  = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      hcnt   <= '0;
      ecnt   <= '0;
      ph     <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        hcnt   <= '0;
        ecnt   <= '0;
        ph     <= 1'b0;
      end
    end else if (tick) begin
      hcnt <= '0;
      ph   <= ~ph;
      ecnt <= ecnt + EW'(1);
      if (last_o) busy_q <= 1'b0;
    end else begin
      hcnt <= hcnt + DW'(1);
    end
  end

  // R7
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> sck_o == cpol_i);
  // R10
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(fin_o));
endmodule

// File: rtl/spi_rt_shifter.sv
module spi_rt_shifter #(
  parameter  int DW = 16,
  localparam int HW = DW/2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] tx_i,
  input  logic          size16_i,
  input  logic          lsbf_i,
  input  logic          cpha_i,
  input  logic          lead_i,
  input  logic          trail_i,
  input  logic          first_i,
  input  logic          last_i,
  input  logic          fin_i,
  input  logic          miso_i,
  output logic          mosi_o,
  output logic [DW-1:0] rx_o
);
  logic [DW-1:0] tx_sh, rx_sh, rx_nxt, rx_pick, rx_word, rx_q;
  logic          sample, shift;

  assign sample  = cpha_i ? trail_i : lead_i;
  assign shift   = cpha_i ? (lead_i && !first_i) : (trail_i && !last_i);
  assign rx_nxt  = lsbf_i ? {miso_i, rx_sh[DW-1:1]} : {rx_sh[DW-2:0], miso_i};
  assign rx_pick = sample ? rx_nxt : rx_sh;
  assign rx_word = size16_i ? rx_pick
                 : {{HW{1'b0}}, (lsbf_i ? rx_pick[DW-1:HW] : rx_pick[HW-1:0])};
  assign mosi_o  = lsbf_i ? tx_sh[0] : (size16_i ? tx_sh[DW-1] : tx_sh[HW-1]);
  assign rx_o    = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh <= '0;
      rx_sh <= '0;
      rx_q  <= '0;
    end else begin
      if (load_i) begin
        tx_sh <= tx_i;
        rx_sh <= '0;
      end else begin
        if (shift)  tx_sh <= lsbf_i ? (tx_sh >> 1) : (tx_sh << 1);
        if (sample) rx_sh <= rx_nxt;
      end
      if (fin_i) rx_q <= rx_word;
    end
  end

  // R5
  size8_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_i && !size16_i) |=> rx_q[DW-1:HW] == '0);
endmodule

// File: rtl/spi_rt_regs.sv
module spi_rt_regs
  import spi_rt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          busy_i,
  input  logic          fin_i,
  input  logic [DW-1:0] rx_i,
  output logic [CW-1:0] ctrl_o,
  output logic [DW-1:0] baud_o,
  output logic [DW-1:0] txd_o,
  output logic          start_o,
  output logic          irq_o
);
  logic [CW-1:0] ctrl;
  logic [DW-1:0] baud, txd;
  logic          done, rd_rx;

  assign rd_rx   = rd_i && addr_i == A_RXD;
  assign start_o = rd_rx && ctrl[CB_EN] && !busy_i;
  assign ctrl_o  = ctrl;
  assign baud_o  = baud;
  assign txd_o   = txd;
  assign irq_o   = done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl <= CTRL_RST;
      baud <= BAUD_RST;
      txd  <= '0;
      done <= 1'b0;
    end else begin
      if (wr_i) begin
        case (addr_i)
          A_CTRL:  ctrl <= wdata_i[CW-1:0];
          A_BAUD:  baud <= wdata_i;
          A_TXD:   txd  <= wdata_i;
          default: ;
        endcase
      end
      if (fin_i)      done <= 1'b1;
      else if (rd_rx) done <= 1'b0;
    end
  end

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = {{(DW-CW){1'b0}}, ctrl};
      A_BAUD:  rdata_o = baud;
      A_TXD:   rdata_o = txd;
      A_RXD,
      A_SHD:   rdata_o = rx_i;
      A_STAT:  rdata_o = {{(DW-2){1'b0}}, busy_i, done};
      default: rdata_o = '0;
    endcase
  end

  // R2
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> busy_i);
  // R9
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done) |-> $past(fin_i));
  // R3
  shadow_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == A_SHD && done) |=> done);
  // R10
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rx && busy_i && !fin_i) |=> busy_i);
  // R8
  dis_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rx && !ctrl[CB_EN] && !busy_i) |=> !busy_i && !done);
endmodule

// File: rtl/spi_rt_master.sv
module spi_rt_master
  import spi_rt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] bus_addr_i,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          irq_o,
  output logic          sck_o,
  output logic          mosi_o,
  input  logic          miso_i,
  output logic          cs_no,
  output logic          io_oe_o
);
  logic [CW-1:0] ctrl;
  logic [DW-1:0] baud, txd, rx;
  logic          start, busy, lead, trail, first, last, fin;

  spi_rt_regs u_regs (
    .clk_i, .rst_ni,
    .addr_i (bus_addr_i), .wr_i (bus_wr_i), .rd_i (bus_rd_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .busy_i (busy), .fin_i (fin), .rx_i (rx),
    .ctrl_o (ctrl), .baud_o (baud), .txd_o (txd),
    .start_o(start), .irq_o (irq_o)
  );

  spi_rt_clkgen #(.DW(DW)) u_clk (
    .clk_i, .rst_ni,
    .start_i (start), .baud_i (baud),
    .cpol_i  (ctrl[CB_CPOL]), .size16_i(ctrl[CB_SIZE]),
    .sck_o   (sck_o), .busy_o (busy),
    .lead_o  (lead), .trail_o(trail),
    .first_o (first), .last_o (last), .fin_o (fin)
  );

  spi_rt_shifter #(.DW(DW)) u_shf (
    .clk_i, .rst_ni,
    .load_i  (start), .tx_i (txd),
    .size16_i(ctrl[CB_SIZE]), .lsbf_i (ctrl[CB_LSBF]), .cpha_i (ctrl[CB_CPHA]),
    .lead_i  (lead), .trail_i(trail), .first_i(first), .last_i (last),
    .fin_i   (fin), .miso_i (miso_i),
    .mosi_o  (mosi_o), .rx_o (rx)
  );

  assign cs_no   = ctrl[CB_CS];
  assign io_oe_o = ctrl[CB_EN];
endmodule

// File: tb/sim_spi_rt_master.sv
`timescale 1ns/1ps
module sim_spi_rt_master;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic        irq, sck, mosi, cs_n, oe;
  logic        miso = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // slave model state
  bit          b_cpol = 0, b_cpha = 0, b_lsbf = 0;
  int          b_n = 8;
  bit          sl_act = 0;
  logic [15:0] sl_word = '0, sl_cap = '0;
  int          sl_oi = 0, sl_ci = 0;

  always #2.5 clk = ~clk;

  spi_rt_master u0 (
    .clk_i(clk), .rst_ni(rst_ni), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .sck_o(sck),
    .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n), .io_oe_o(oe)
  );

  function automatic logic bit_at(logic [15:0] w, int i);
    return b_lsbf ? w[i] : w[b_n-1-i];
  endfunction

  task automatic sl_drive();
    if (sl_oi < b_n) miso = bit_at(sl_word, sl_oi);
    sl_oi++;
  endtask

  task automatic sl_capture();
    if (sl_ci < b_n) begin
      if (b_lsbf) sl_cap[sl_ci] = mosi;
      else        sl_cap[b_n-1-sl_ci] = mosi;
      sl_ci++;
    end
  endtask

  always @(sck) begin
    if (sl_act) begin
      if (sck != b_cpol) begin
        if (b_cpha) sl_drive(); else sl_capture();
      end else begin
        if (b_cpha) sl_capture(); else sl_drive();
      end
    end
  end

  task automatic sl_arm(logic [15:0] w);
    sl_word = w; sl_oi = 0; sl_ci = 0; sl_cap = '0;
    if (!b_cpha) sl_drive();
    sl_act = 1;
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(posedge clk); #1 wr = 0;
  endtask

  task automatic rd_reg(logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd = 1;
    #1 d = rdata;
    @(posedge clk); #1 rd = 0;
  endtask

  // cycles since trigger edge until irq; c0 = cycles already spent
  task automatic wait_irq(int c0, output int cyc);
    cyc = c0;
    while (!irq && cyc < 2000) begin
      @(posedge clk); cyc++; #1;
    end
  endtask

  function automatic logic [15:0] ctrl_word(bit en, bit cpol, bit cpha, bit lsbf, bit s16, bit cs);
    return {9'd0, cs, s16, lsbf, cpha, cpol, 1'b1, en};
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      summary();
    end
  end

  initial begin
    logic [15:0] d, mask, tx, sw, prev;
    int cyc;
    bit cs_moved, prev_ok;
    prev = '0; prev_ok = 0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    // R1 reset state
    rd_reg(3'd0, d); chk(d == 16'h0043, "R1 ctrl", d, 16'h43);
    rd_reg(3'd1, d); chk(d == 16'd4, "R1 baud", d, 4);
    rd_reg(3'd5, d); chk(d == 16'd0, "R1 status", d, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    chk(cs_n == 1, "R1 cs", cs_n, 1);
    chk(oe == 1, "R1 oe", oe, 1);

    wr_reg(3'd1, 16'd2);
    for (int m = 0; m < 16; m++) begin
      b_cpol = m[0]; b_cpha = m[1]; b_lsbf = m[2]; b_n = m[3] ? 16 : 8;
      mask = m[3] ? 16'hFFFF : 16'h00FF;
      wr_reg(3'd0, ctrl_word(1, b_cpol, b_cpha, b_lsbf, m[3], 0));
      #1 chk(sck == b_cpol, "R7 sck idle", sck, b_cpol);
      chk(cs_n == 0, "R11 cs follows bit", cs_n, 0);
      for (int w = 0; w < 2; w++) begin
        tx = 16'hA5C3 ^ 16'(m * 16'h1357) ^ (w != 0 ? 16'h0FF0 : 16'h0000);
        sw = {tx[6:0], tx[15:7]} ^ 16'h6B29;
        wr_reg(3'd2, tx);
        sl_arm(sw);
        rd_reg(3'd3, d);
        if (prev_ok) chk(d == prev, "R2 rx read value", d, prev);
        chk(irq == 0, "R9 irq cleared by rx read", irq, 0);
        cs_moved = 0;
        cyc = 0;
        while (!irq && cyc < 2000) begin
          @(posedge clk); cyc++; #1;
          if (cs_n != 0) cs_moved = 1;
        end
        chk(cyc == 2*b_n*2, "R4 transfer cycles", cyc, 2*b_n*2);
        chk(!cs_moved, "R11 cs stable", cs_moved, 0);
        chk(sl_cap == (tx & mask), "R6 R7 mosi word", sl_cap, tx & mask);
        rd_reg(3'd4, d);
        chk(d == (sw & mask), "R5 R6 rx word", d, sw & mask);
        chk(irq == 1, "R3 shadow keeps flag", irq, 1);
        rd_reg(3'd5, d);
        chk(d == 16'h0001, "R3 no transfer from shadow", d, 1);
        sl_act = 0;
        prev = sw & mask; prev_ok = 1;
      end
    end

    // R4 divider sweep, 8-bit mode 0
    b_cpol = 0; b_cpha = 0; b_lsbf = 0; b_n = 8;
    wr_reg(3'd0, ctrl_word(1, 0, 0, 0, 0, 1));
    for (int i = 0; i < 5; i++) begin
      int b, h;
      b = (i == 0) ? 0 : 2*i - 1;
      h = (b < 2) ? 2 : b;
      wr_reg(3'd1, 16'(b));
      wr_reg(3'd2, 16'h005A);
      sl_arm(16'h00C6);
      rd_reg(3'd3, d);
      wait_irq(0, cyc);
      chk(cyc == 16*h, "R4 divider", cyc, 16*h);
      sl_act = 0;
    end

    // R10 trigger while busy is ignored
    wr_reg(3'd1, 16'd3);
    wr_reg(3'd2, 16'h0093);
    sl_arm(16'h0017);
    rd_reg(3'd3, d);
    rd_reg(3'd5, d);
    chk(d[1] == 1, "R10 busy set", d, 2);
    rd_reg(3'd3, d);
    wait_irq(2, cyc);
    chk(cyc == 48, "R10 busy read ignored", cyc, 48);
    chk(sl_cap == 16'h0093, "R10 word intact", sl_cap, 16'h93);
    rd_reg(3'd4, d);
    chk(d == 16'h0017, "R10 rx intact", d, 16'h17);
    rd_reg(3'd5, d);
    chk(d == 16'h0001, "R10 busy cleared", d, 1);
    sl_act = 0;

    // R8 disabled
    wr_reg(3'd0, ctrl_word(0, 0, 0, 0, 0, 1));
    #1 chk(oe == 0, "R8 oe low", oe, 0);
    rd_reg(3'd3, d);
    repeat (4) @(posedge clk);
    #1 chk(irq == 0, "R8 flag cleared", irq, 0);
    rd_reg(3'd5, d);
    chk(d == 16'h0000, "R8 no transfer", d, 0);
    wr_reg(3'd0, ctrl_word(1, 0, 0, 0, 0, 1));
    #1 chk(oe == 1, "R8 oe restored", oe, 1);
    chk(cs_n == 1, "R11 cs high", cs_n, 1);

    finished = 1;
    summary();
  end
endmodule